// File: doc/BRIEF.md
# Receive Descriptor Ring Engine

This block is the receive side of a DMA-style Ethernet MAC. Software prepares a ring of buffer descriptors in a small on-chip descriptor memory. Each descriptor has a 16-bit status word and a 16-bit length word. Software hands a descriptor to the engine by setting its empty bit. The engine takes each received frame into the descriptor at its ring pointer. It writes the length and the error and size flags, then clears the empty bit so the descriptor belongs to software again. The ring pointer then moves to the next descriptor, or back to index 0 when the descriptor carried a wrap bit.

Received frames arrive as a byte stream. A strobe marks each byte, and the final byte carries a last marker together with the per-frame error indications. Payload bytes are only counted; they are never stored. The engine stalls when the descriptor at its ring pointer is not empty. While stalled it drops whole frames and counts each one, and it stays stalled until software pulses the descriptors-active strobe. Each completed frame sets a frame-received event. Software clears that event by writing a one to it.

Top module: `rxd_ring_engine`

## Requirements
- R1: A frame is stored only if the descriptor at the ring pointer has its empty bit (status bit 15) set when the first byte of the frame arrives. Storing the frame clears bit 15.
- R2: After a descriptor is stored, the ring pointer goes to index 0 if that descriptor had its wrap bit (status bit 13) set, or if it was the last index (DEPTH-1). Otherwise the pointer goes to the next index.
- R3: Every stored status word has its last-in-frame bit (bit 11) set and keeps the wrap bit it had before. All other bits are cleared before the flags are added.
- R4: The stored length word is the number of bytes received, including the 4-byte frame check sequence, limited to a maximum of 1520.
- R5: Status bit 5 (too long) is set when more than 1518 bytes were received. Status bit 4 (too short) is set when fewer than 64 bytes were received.
- R6: The error inputs are sampled with the last byte of the frame. Each one sets its own status bit: late collision bit 3, non-octet alignment bit 2, CRC error bit 1, FIFO overrun bit 0.
- R7: `stalled_o` is 1 out of reset. It becomes 1 when the engine is idle and the descriptor at the ring pointer is not empty, or when a frame arrives for such a descriptor. It stays 1 until `rdar_i` is pulsed.
- R8: `frame_evt_o` is set one cycle after the last byte of each stored frame. `evt_clr_i` clears it. When a frame completes in the same cycle as a clear, the event stays set.
- R9: A frame that arrives while the engine is stalled is dropped and changes no descriptor. It adds one to `ovr_cnt_o`, which stops at its maximum value.
- R10: `idle_o` is 0 from the cycle after the first byte of a frame until the last byte has been taken.
- R11: Software writes the status word (`sw_len_sel_i`=0) or the length word (`sw_len_sel_i`=1) of entry `sw_addr_i`, and reads both words of that entry back combinationally. `desc_wr_o` pulses, with `desc_wr_idx_o` set to the stored index, during the cycle of the last byte of a stored frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rx_valid_i | input | 1 | One received byte in this cycle |
| rx_last_i | input | 1 | This byte is the last byte of the frame |
| rx_crc_err_i | input | 1 | CRC error, sampled with the last byte |
| rx_align_err_i | input | 1 | Non-octet alignment, sampled with the last byte |
| rx_fifo_ovr_i | input | 1 | Receive FIFO overrun, sampled with the last byte |
| rx_late_coll_i | input | 1 | Late collision, sampled with the last byte |
| rdar_i | input | 1 | Descriptors-active strobe; clears the stall |
| evt_clr_i | input | 1 | Write-one-to-clear for the frame event |
| sw_we_i | input | 1 | Software write to the descriptor memory |
| sw_len_sel_i | input | 1 | 0 selects the status word, 1 selects the length word |
| sw_addr_i | input | IDX_W | Descriptor index for software reads and writes |
| sw_wdata_i | input | 16 | Software write data |
| sw_stat_o | output | 16 | Status word of entry sw_addr_i |
| sw_len_o | output | 16 | Length word of entry sw_addr_i |
| desc_wr_o | output | 1 | The engine writes back a descriptor in this cycle |
| desc_wr_idx_o | output | IDX_W | Index being written back (the ring pointer) |
| frame_evt_o | output | 1 | Frame-received event |
| stalled_o | output | 1 | The engine is stalled on a descriptor that is not empty |
| idle_o | output | 1 | No frame is being received |
| ovr_cnt_o | output | CNT_W | Count of dropped frames, saturating |

## Verification
Frame lengths are chosen around each threshold: 1, 63/64, 1518/1519 and above 1520. This separates the too-short and too-long comparisons, which both compare against the unclamped count, from the length limit, which applies only to the stored length word. The error inputs are randomized one by one, so a swapped bit position shows up as a wrong status readback. The ring is first run with a wrap bit at index 5 and then with no wrap bits at all. The first run shows whether the engine follows the wrap bit; the second shows whether it still returns to 0 at the end of the memory. Filling the ring and sending frames after it is full shows that a dropped frame leaves the descriptor unchanged and adds one to the counter. One frame ends in the same cycle as an event clear, to check that the set has priority.

// File: rtl/rxd_pkg.sv
package rxd_pkg;
  localparam int unsigned WORD_W  = 16;
  localparam int unsigned EMPTY_B = 15;
  localparam int unsigned WRAP_B  = 13;
  localparam int unsigned LAST_B  = 11;
  localparam int unsigned FLAG_W  = 6;

  // bit 5 down to bit 0 of the status word
  typedef struct packed {
    logic too_long;
    logic too_short;
    logic late_coll;
    logic misalign;
    logic crc_err;
    logic fifo_ovr;
  } rx_flags_t;
endpackage

// File: rtl/rxd_desc_mem.sv
module rxd_desc_mem
  import rxd_pkg::*;
#(
  parameter int unsigned DEPTH = 8,
  parameter int unsigned IDX_W = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sw_we_i,
  input  logic              sw_len_sel_i,
  input  logic [IDX_W-1:0]  sw_addr_i,
  input  logic [WORD_W-1:0] sw_wdata_i,
  output logic [WORD_W-1:0] sw_stat_o,
  output logic [WORD_W-1:0] sw_len_o,
  input  logic [IDX_W-1:0]  rd_idx_i,
  output logic [WORD_W-1:0] rd_stat_o,
  input  logic              wr_en_i,
  input  logic [IDX_W-1:0]  wr_idx_i,
  input  logic [WORD_W-1:0] wr_stat_i,
  input  logic [WORD_W-1:0] wr_len_i
);
  logic [WORD_W-1:0] stat_q [DEPTH];
  logic [WORD_W-1:0] len_q  [DEPTH];

  // engine write-back wins over a software write to the same entry
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < DEPTH; i++) begin
        stat_q[i] <= '0;
        len_q[i]  <= '0;
      end
    end else begin
      for (int i = 0; i < DEPTH; i++) begin
        if (wr_en_i && wr_idx_i == IDX_W'(i)) begin
          stat_q[i] <= wr_stat_i;
          len_q[i]  <= wr_len_i;
        end else if (sw_we_i && sw_addr_i == IDX_W'(i)) begin
          if (sw_len_sel_i) len_q[i]  <= sw_wdata_i;
          else              stat_q[i] <= sw_wdata_i;
        end
      end
    end
  end

  assign sw_stat_o = stat_q[sw_addr_i];
  assign sw_len_o  = len_q[sw_addr_i];
  assign rd_stat_o = stat_q[rd_idx_i];

  // R1: engine only writes descriptors it owns
  p_own_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i |-> stat_q[wr_idx_i][EMPTY_B]);
  // R3: written status is closed and marked last
  p_last_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i |=> !stat_q[$past(wr_idx_i)][EMPTY_B] && stat_q[$past(wr_idx_i)][LAST_B]);
endmodule

// File: rtl/rxd_frame_acc.sv
module rxd_frame_acc
  import rxd_pkg::*;
#(
  parameter int unsigned MAX_BUF = 1520,
  parameter int unsigned MAX_FRM = 1518,
  parameter int unsigned MIN_FRM = 64
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  logic              last_i,
  input  logic              crc_err_i,
  input  logic              align_err_i,
  input  logic              fifo_ovr_i,
  input  logic              late_coll_i,
  output logic              sof_o,
  output logic              eof_o,
  output logic              busy_o,
  output logic [WORD_W-1:0] len_o,
  output rx_flags_t         flags_o
);
  logic [WORD_W-1:0] cnt_q, beat_len;

  assign beat_len = (&cnt_q) ? cnt_q : cnt_q + 1'b1;
  assign sof_o    = valid_i && (cnt_q == '0);
  assign eof_o    = valid_i && last_i;
  assign busy_o   = (cnt_q != '0);
  assign len_o    = (beat_len > WORD_W'(MAX_BUF)) ? WORD_W'(MAX_BUF) : beat_len;

  always_comb begin
    flags_o.too_long  = beat_len > WORD_W'(MAX_FRM);
    flags_o.too_short = beat_len < WORD_W'(MIN_FRM);
    flags_o.late_coll = late_coll_i;
    flags_o.misalign  = align_err_i;
    flags_o.crc_err   = crc_err_i;
    flags_o.fifo_ovr  = fifo_ovr_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      cnt_q <= '0;
    else if (valid_i) cnt_q <= last_i ? '0 : beat_len;
  end

  // R4: stored length never exceeds the buffer
  p_len_cap_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    eof_o |-> len_o <= WORD_W'(MAX_BUF));
  // R10: a frame in progress keeps the block busy
  p_busy_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && !last_i |=> busy_o);
endmodule

// File: rtl/rxd_ring_ctrl.sv
module rxd_ring_ctrl
  import rxd_pkg::*;
#(
  parameter int unsigned DEPTH = 8,
  parameter int unsigned IDX_W = 3,
  parameter int unsigned CNT_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sof_i,
  input  logic              eof_i,
  input  logic              busy_i,
  input  logic [WORD_W-1:0] len_i,
  input  rx_flags_t         flags_i,
  input  logic              rdar_i,
  input  logic              evt_clr_i,
  input  logic [WORD_W-1:0] rd_stat_i,
  output logic [IDX_W-1:0]  cur_o,
  output logic              wr_en_o,
  output logic [WORD_W-1:0] wr_stat_o,
  output logic [WORD_W-1:0] wr_len_o,
  output logic              stalled_o,
  output logic              evt_o,
  output logic [CNT_W-1:0]  ovr_cnt_o
);
  logic [IDX_W-1:0] cur_q, cur_nxt;
  logic             stalled_q, drop_q, evt_q;
  logic [CNT_W-1:0] ovr_q;
  logic             owned, accept, dropping, stall_set;

  assign owned    = rd_stat_i[EMPTY_B];
  assign accept   = !stalled_q && owned;
  assign dropping = sof_i ? !accept : drop_q;
  assign wr_en_o  = eof_i && !dropping;
  assign wr_len_o = len_i;
  assign wr_stat_o = {{(WORD_W-FLAG_W){1'b0}}, flags_i}
                   | (WORD_W'(1) << LAST_B)
                   | (rd_stat_i & (WORD_W'(1) << WRAP_B));

  assign cur_nxt = (rd_stat_i[WRAP_B] || cur_q == IDX_W'(DEPTH-1)) ? '0 : cur_q + 1'b1;

  // reject at frame start, or idle poll of a descriptor owned by software
  assign stall_set = (sof_i && !accept) ||
                     (!stalled_q && !busy_i && !sof_i && !owned);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cur_q     <= '0;
      stalled_q <= 1'b1;
      drop_q    <= 1'b0;
      evt_q     <= 1'b0;
      ovr_q     <= '0;
    end else begin
      if (wr_en_o) cur_q <= cur_nxt;

      if (rdar_i)         stalled_q <= 1'b0;
      else if (stall_set) stalled_q <= 1'b1;

      if (eof_i)      drop_q <= 1'b0;
      else if (sof_i) drop_q <= !accept;

      if (wr_en_o)        evt_q <= 1'b1;
      else if (evt_clr_i) evt_q <= 1'b0;

      if (eof_i && dropping && !(&ovr_q)) ovr_q <= ovr_q + 1'b1;
    end
  end

  assign cur_o     = cur_q;
  assign stalled_o = stalled_q;
  assign evt_o     = evt_q;
  assign ovr_cnt_o = ovr_q;

  // R2: wrap bit sends the pointer home
  p_wrap_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_o && rd_stat_i[WRAP_B] |=> cur_q == '0);
  // R7: stall is held until the active strobe
  p_stall_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stalled_q && !rdar_i |=> stalled_q);
  // R9: a stalled engine does not move
  p_idx_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stalled_q |=> cur_q == $past(cur_q));
  // R9: overrun counter never decreases
  p_ovr_mono_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovr_q >= $past(ovr_q));
  // R8: completion raises the event
  p_evt_set_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_o |=> evt_q);
endmodule

// File: rtl/rxd_ring_engine.sv
module rxd_ring_engine
  import rxd_pkg::*;
#(
  parameter int unsigned DEPTH   = 8,
  parameter int unsigned CNT_W   = 8,
  parameter int unsigned MAX_BUF = 1520,
  parameter int unsigned MAX_FRM = 1518,
  parameter int unsigned MIN_FRM = 64,
  localparam int unsigned IDX_W  = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              rx_valid_i,
  input  logic              rx_last_i,
  input  logic              rx_crc_err_i,
  input  logic              rx_align_err_i,
  input  logic              rx_fifo_ovr_i,
  input  logic              rx_late_coll_i,
  input  logic              rdar_i,
  input  logic              evt_clr_i,
  input  logic              sw_we_i,
  input  logic              sw_len_sel_i,
  input  logic [IDX_W-1:0]  sw_addr_i,
  input  logic [WORD_W-1:0] sw_wdata_i,
  output logic [WORD_W-1:0] sw_stat_o,
  output logic [WORD_W-1:0] sw_len_o,
  output logic              desc_wr_o,
  output logic [IDX_W-1:0]  desc_wr_idx_o,
  output logic              frame_evt_o,
  output logic              stalled_o,
  output logic              idle_o,
  output logic [CNT_W-1:0]  ovr_cnt_o
);
  logic              sof, eof, busy, wr_en;
  logic [WORD_W-1:0] len, rd_stat, wr_stat, wr_len;
  logic [IDX_W-1:0]  cur;
  rx_flags_t         flags;

  rxd_frame_acc #(
    .MAX_BUF(MAX_BUF), .MAX_FRM(MAX_FRM), .MIN_FRM(MIN_FRM)
  ) u_acc (
    .clk_i, .rst_ni,
    .valid_i(rx_valid_i), .last_i(rx_last_i),
    .crc_err_i(rx_crc_err_i), .align_err_i(rx_align_err_i),
    .fifo_ovr_i(rx_fifo_ovr_i), .late_coll_i(rx_late_coll_i),
    .sof_o(sof), .eof_o(eof), .busy_o(busy), .len_o(len), .flags_o(flags)
  );

  rxd_ring_ctrl #(.DEPTH(DEPTH), .IDX_W(IDX_W), .CNT_W(CNT_W)) u_ctrl (
    .clk_i, .rst_ni,
    .sof_i(sof), .eof_i(eof), .busy_i(busy), .len_i(len), .flags_i(flags),
    .rdar_i, .evt_clr_i, .rd_stat_i(rd_stat),
    .cur_o(cur), .wr_en_o(wr_en), .wr_stat_o(wr_stat), .wr_len_o(wr_len),
    .stalled_o, .evt_o(frame_evt_o), .ovr_cnt_o
  );

  rxd_desc_mem #(.DEPTH(DEPTH), .IDX_W(IDX_W)) u_mem (
    .clk_i, .rst_ni,
    .sw_we_i, .sw_len_sel_i, .sw_addr_i, .sw_wdata_i, .sw_stat_o, .sw_len_o,
    .rd_idx_i(cur), .rd_stat_o(rd_stat),
    .wr_en_i(wr_en), .wr_idx_i(cur), .wr_stat_i(wr_stat), .wr_len_i(wr_len)
  );

  assign desc_wr_o     = wr_en;
  assign desc_wr_idx_o = cur;
  assign idle_o        = !busy;
endmodule

// File: tb/rxd_ring_engine_tb.sv
module rxd_ring_engine_tb;
  localparam int DEPTH = 8;
  localparam int IDX_W = 3;

  logic clk = 1'b0, rst_n = 1'b0;
  logic rx_valid = 0, rx_last = 0, crc = 0, aln = 0, fov = 0, lcol = 0;
  logic rdar = 0, evt_clr = 0, sw_we = 0, sw_sel = 0;
  logic [IDX_W-1:0] sw_addr = '0;
  logic [15:0] sw_wdata = '0;
  logic [15:0] sw_stat, sw_len;
  logic desc_wr, frame_evt, stalled, idle;
  logic [IDX_W-1:0] desc_wr_idx;
  logic [7:0] ovr_cnt;

  always #5 clk = ~clk;

  rxd_ring_engine #(.DEPTH(DEPTH)) u_dut (
    .clk_i(clk), .rst_ni(rst_n),
    .rx_valid_i(rx_valid), .rx_last_i(rx_last), .rx_crc_err_i(crc),
    .rx_align_err_i(aln), .rx_fifo_ovr_i(fov), .rx_late_coll_i(lcol),
    .rdar_i(rdar), .evt_clr_i(evt_clr), .sw_we_i(sw_we), .sw_len_sel_i(sw_sel),
    .sw_addr_i(sw_addr), .sw_wdata_i(sw_wdata), .sw_stat_o(sw_stat), .sw_len_o(sw_len),
    .desc_wr_o(desc_wr), .desc_wr_idx_o(desc_wr_idx), .frame_evt_o(frame_evt),
    .stalled_o(stalled), .idle_o(idle), .ovr_cnt_o(ovr_cnt)
  );

  int n_chk = 0, n_fail = 0;
  bit done = 0;
  int exp_stat [DEPTH];
  int exp_len  [DEPTH];
  int ptr = 0, ovr_m = 0;
  bit stalled_m = 1;

  task automatic chk(string tag, int act, int exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  function automatic int exp_flags(int len, bit c, bit a, bit f, bit l);
    return ((len > 1518) << 5) | ((len < 64) << 4) | (l << 3) | (a << 2) | (c << 1) | int'(f);
  endfunction

  task automatic sw_write(int a, bit sel, int d);
    @(negedge clk);
    sw_we = 1; sw_addr = IDX_W'(a); sw_sel = sel; sw_wdata = 16'(d);
    @(negedge clk);
    sw_we = 0;
    if (sel) exp_len[a] = d; else exp_stat[a] = d;
  endtask

  task automatic sw_read(int a, output int st, output int ln);
    @(negedge clk);
    sw_addr = IDX_W'(a);
    #1;
    st = int'(sw_stat); ln = int'(sw_len);
  endtask

  task automatic pulse_rdar();
    @(negedge clk); rdar = 1;
    @(negedge clk); rdar = 0;
    stalled_m = 0;
  endtask

  task automatic arm_ring(int wrap_idx);
    for (int i = 0; i < DEPTH; i++) begin
      sw_write(i, 1, 0);
      sw_write(i, 0, (i == wrap_idx) ? 16'hA000 : 16'h8000);
    end
  endtask

  task automatic send_frame(int len, bit c, bit a, bit f, bit l, bit clr_last);
    bit acc;
    int idx, fl, st, ln, wr_seen, wr_idx;
    acc = !stalled_m && exp_stat[ptr][15];
    idx = ptr;
    wr_seen = 0; wr_idx = 0;
    for (int i = 0; i < len; i++) begin
      @(negedge clk);
      rx_valid = 1; rx_last = (i == len - 1);
      crc = (i == len - 1) & c; aln = (i == len - 1) & a;
      fov = (i == len - 1) & f; lcol = (i == len - 1) & l;
      evt_clr = (i == len - 1) & clr_last;
      #1;
      if (i == 1 && len > 2) chk("R10 idle low mid-frame", int'(idle), 0);
      if (i == len - 1) begin wr_seen = int'(desc_wr); wr_idx = int'(desc_wr_idx); end
    end
    @(negedge clk);
    rx_valid = 0; rx_last = 0; crc = 0; aln = 0; fov = 0; lcol = 0; evt_clr = 0;
    fl = exp_flags(len, c, a, f, l);
    if (acc) begin
      chk("R11 desc_wr pulse", wr_seen, 1);
      chk("R11 desc_wr idx", wr_idx, idx);
      chk("R8 event set", int'(frame_evt), 1);
      exp_stat[idx] = (exp_stat[idx] & 16'h2000) | 16'h0800 | fl;
      exp_len[idx]  = (len > 1520) ? 1520 : len;
      ptr = ((exp_stat[idx] & 16'h2000) != 0 || idx == DEPTH - 1) ? 0 : idx + 1;
    end else begin
      chk("R9 no write on drop", wr_seen, 0);
      ovr_m = (ovr_m < 255) ? ovr_m + 1 : 255;
      stalled_m = 1;
    end
    @(negedge clk);
    sw_read(idx, st, ln);
    chk(acc ? "R3 R5 R6 status word" : "R1 R9 dropped status", st, exp_stat[idx]);
    chk(acc ? "R4 length word" : "R9 dropped length", ln, exp_len[idx]);
    chk("R9 overrun count", int'(ovr_cnt), ovr_m);
    if (!exp_stat[ptr][15]) stalled_m = 1;
    chk("R7 stall status", int'(stalled), int'(stalled_m));
    chk("R2 pointer via desc_wr_idx", int'(desc_wr_idx), ptr);
    chk("R10 idle after frame", int'(idle), 1);
    if (acc) begin
      @(negedge clk); evt_clr = 1;
      @(negedge clk); evt_clr = 0;
      #1;
      chk("R8 event cleared", int'(frame_evt), 0);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    int st, ln, n, r, len;
    void'($urandom(32'd1234));
    for (int i = 0; i < DEPTH; i++) begin exp_stat[i] = 0; exp_len[i] = 0; end
    repeat (3) @(negedge clk);
    rst_n = 1;
    #1;
    chk("R7 stalled after reset", int'(stalled), 1);
    chk("R10 idle after reset", int'(idle), 1);
    chk("R8 event after reset", int'(frame_evt), 0);
    chk("R9 overrun after reset", int'(ovr_cnt), 0);

    // dropped while stalled out of reset
    send_frame(10, 0, 0, 0, 0, 0);

    // ring of six descriptors, wrap at index 5
    arm_ring(5);
    sw_read(5, st, ln);
    chk("R11 status readback", st, 16'hA000);
    chk("R11 length readback", ln, 0);
    pulse_rdar();
    @(negedge clk); #1;
    chk("R7 stall cleared by rdar", int'(stalled), 0);

    send_frame(64, 0, 0, 0, 0, 0);
    send_frame(63, 1, 0, 0, 0, 0);
    send_frame(1518, 0, 1, 0, 0, 0);
    send_frame(1519, 0, 0, 1, 0, 1);
    send_frame(1525, 0, 0, 0, 1, 0);
    send_frame(1, 1, 1, 1, 1, 0);
    // ring full: pointer back at 0, owned by software
    send_frame(70, 0, 0, 0, 0, 0);

    // rings with no wrap bits, random traffic
    for (int round = 0; round < 3; round++) begin
      arm_ring(-1);
      pulse_rdar();
      n = 9 + int'($urandom % 3);
      for (int k = 0; k < n; k++) begin
        r = int'($urandom % 4);
        case (r)
          0: len = 1 + int'($urandom % 70);
          1: len = 60 + int'($urandom % 10);
          2: len = 1512 + int'($urandom % 14);
          default: len = 64 + int'($urandom % 300);
        endcase
        send_frame(len, 1'($urandom), 1'($urandom), 1'($urandom), 1'($urandom), 1'($urandom % 4 == 0));
      end
    end

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end
endmodule